// File: doc/BRIEF.md
# Power-Delay-Profile Bin Update Datapath

This block folds one finished coherent correlation segment into one bin of a power-delay profile. Each accepted update carries the signed I and Q coherent sums, the number of windows N that the segment covered, a 4-bit gain shift, a 4-bit alpha index, the bin's previous 18-bit value and the ID of the result that owns the bin. The block computes the segment's power, normalises it by 1/N so that segments of different lengths carry comparable weight, applies the gain shift, and then either adds the power to the bin (plain accumulation) or moves the bin towards it by a fraction alpha (exponential time-weighted averaging). All arithmetic saturates to the 18-bit range.

The block is a three-stage pipeline that accepts one update every cycle. Storage of the bins and the correlator sit outside it. For every result ID it keeps a sticky flag that records saturation. An update can carry a clear request, and the flag it writes back then reflects only that update.

Top module: `pdp_update`

## Requirements
- R1: After reset `outValid` is low, and every per-result saturation flag is clear. The first update of any ID that does not saturate reports `outSat` = 0.
- R2: An update accepted with `inValid` high in cycle t produces `outValid` high in cycle t+3, with `outResId` equal to its `resId`. Back-to-back updates are accepted every cycle, with no gaps.
- R3: The normalised power is NP = floor(floor((I*I + Q*Q) * R) * 2^S / 2^35). Here R = floor(2^17 / N) for N in 1..32, and R = 0 for N = 0 or N > 32. S is `pwrShift`.
- R4: When NP exceeds 131071, it is clamped to 131071 and the update counts as saturated.
- R5: When `alphaIdx` = 0, the new bin is P + NP, where P is `prevBin`.
- R6: When `alphaIdx` = k in 1..15, A = floor(2^17 * a_k), with a_k in index order 1, 2/3, 1/2, 1/3, 1/4, 1/6, 1/8, 1/12, 1/16, 1/24, 1/32, 1/48, 1/64, 1/96, 1/128. The new bin is P + trunc((NP - P) * A / 2^17), where trunc rounds toward zero.
- R7: The new bin is clamped to the signed range -131072..131071, and a clamp counts as saturated.
- R8: A saturated update sets the flag of its ID. Later non-saturating updates of that ID still report `outSat` = 1. Other IDs are unaffected.
- R9: An update with `clrSat` high writes back, and reports, only its own saturation status. Any earlier flag value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Update present this cycle |
| iSum | input | 18 | Signed coherent I sum |
| qSum | input | 18 | Signed coherent Q sum |
| nLen | input | 6 | Coherent segment length in windows |
| pwrShift | input | 4 | Gain shift applied to the power |
| alphaIdx | input | 4 | Alpha index; 0 selects plain accumulation |
| prevBin | input | 18 | Signed previous bin value |
| resId | input | 6 | Result ID that owns the bin |
| clrSat | input | 1 | Clear this result's saturation flag on this update |
| outValid | output | 1 | New bin present |
| newBin | output | 18 | Signed updated bin value |
| outResId | output | 6 | Result ID of the new bin |
| outSat | output | 1 | Sticky saturation flag of that result after this update |

## Verification
The bench goes after the arithmetic edges first. Full-scale I and Q with a large shift overflow the power clamp, and a design that wrapped there would return a small or negative power. A bin near the positive limit under accumulation would, without the final clamp, wrap to a large negative value. Negative (NP - P) products with inexact alpha entries such as 2/3 or 1/96 differ by one code if the rounding floors instead of truncating. Segment lengths of 0 and above 32 expose a reciprocal table that is indexed out of range. For the flags, the bench saturates one ID and then updates it cleanly, both with and without a clear. A design that cleared too early, leaked between IDs, or forgot the same-update saturation on a clear would report the wrong `outSat`.

// File: rtl/pdp_update_pkg.sv
package pdp_update_pkg;

  localparam int ALPHA_FRAC = 17;
  localparam int ALPHA_W    = ALPHA_FRAC + 1;

  // Stage advance strobes from control to datapath.
  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
  } pdpStrobe_t;

  // Weighting fractions in unsigned Q1.17, truncated. Index 0 means weight 1.
  function automatic logic [ALPHA_W-1:0] alphaLookup(input logic [3:0] idx);
    logic [ALPHA_W-1:0] a;
    case (idx)
      4'd0:  a = 18'd131072;
      4'd1:  a = 18'd131072;
      4'd2:  a = 18'd87381;
      4'd3:  a = 18'd65536;
      4'd4:  a = 18'd43690;
      4'd5:  a = 18'd32768;
      4'd6:  a = 18'd21845;
      4'd7:  a = 18'd16384;
      4'd8:  a = 18'd10922;
      4'd9:  a = 18'd8192;
      4'd10: a = 18'd5461;
      4'd11: a = 18'd4096;
      4'd12: a = 18'd2730;
      4'd13: a = 18'd2048;
      4'd14: a = 18'd1365;
      default: a = 18'd1024;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/pdp_update_dp.sv
module pdp_update_dp
  import pdp_update_pkg::*;
#(
  parameter int SUM_W       = 18,
  parameter int DATA_W      = 18,
  parameter int SHIFT_W     = 4,
  parameter int WIN_PER_BIT = 4,
  parameter int BITS_MAX    = 8
) (
  input  logic                     clk,
  input  pdpStrobe_t               stb,
  input  logic signed [SUM_W-1:0]  iSum,
  input  logic signed [SUM_W-1:0]  qSum,
  input  logic [$clog2(BITS_MAX*WIN_PER_BIT+1)-1:0] nLen,
  input  logic [SHIFT_W-1:0]       pwrShift,
  input  logic [3:0]               alphaIdx,
  input  logic signed [DATA_W-1:0] prevBin,
  output logic signed [DATA_W-1:0] binOut,
  output logic                     satNow
);

  localparam int MAX_N      = BITS_MAX * WIN_PER_BIT;
  localparam int N_W        = $clog2(MAX_N + 1);
  localparam int RECIP_W    = ALPHA_FRAC + 1;
  localparam int RECIP_ONE  = 2 ** ALPHA_FRAC;
  localparam int PWR_W      = 2 * SUM_W + 1;
  localparam int WIDE_W     = PWR_W + RECIP_W + (2 ** SHIFT_W - 1);
  localparam int NORM_SHIFT = 2 * SUM_W - 1;
  localparam int NP_MAX     = 2 ** (DATA_W - 1) - 1;
  localparam int DIFF_W     = DATA_W + 1;
  localparam int PROD_W     = 2 * DIFF_W;
  localparam logic signed [PROD_W-1:0] BIN_MAX = PROD_W'(NP_MAX);
  localparam logic signed [PROD_W-1:0] BIN_MIN = -BIN_MAX - PROD_W'(1);

  // Reciprocal table for 1/N; out-of-range lengths read zero.
  logic [RECIP_W-1:0] recipRom [2**N_W];
  for (genvar k = 0; k < 2 ** N_W; k++) begin : g_recip
    if (k == 0 || k > MAX_N) begin : g_zero
      assign recipRom[k] = '0;
    end else begin : g_val
      assign recipRom[k] = RECIP_W'(RECIP_ONE / k);
    end
  end

  // Stage 1: power and reciprocal
  logic signed [PWR_W-1:0] iExt, qExt, pwrComb;
  assign iExt    = PWR_W'(iSum);
  assign qExt    = PWR_W'(qSum);
  assign pwrComb = iExt * iExt + qExt * qExt;

  logic [PWR_W-1:0]          pwrQ;
  logic [RECIP_W-1:0]        recipQ;
  logic [SHIFT_W-1:0]        shQ;
  logic [3:0]                aiQ;
  logic signed [DATA_W-1:0]  prev1Q;

  always_ff @(posedge clk) begin
    if (stb.s1En) begin
      pwrQ   <= $unsigned(pwrComb);
      recipQ <= recipRom[nLen];
      shQ    <= pwrShift;
      aiQ    <= alphaIdx;
      prev1Q <= prevBin;
    end
  end

  // Stage 2: normalise, gain shift, clamp, alpha lookup
  logic [WIDE_W-1:0] wide, npWide;
  logic              npSat;
  assign wide   = (WIDE_W'(pwrQ) * WIDE_W'(recipQ)) << shQ;
  assign npWide = wide >> NORM_SHIFT;
  assign npSat  = npWide > WIDE_W'(NP_MAX);

  logic [DATA_W-1:0]         npQ;
  logic [ALPHA_W-1:0]        alphaQ;
  logic                      usePrevQ;
  logic                      sat1Q;
  logic signed [DATA_W-1:0]  prev2Q;

  always_ff @(posedge clk) begin
    if (stb.s2En) begin
      npQ      <= npSat ? DATA_W'(NP_MAX) : npWide[DATA_W-1:0];
      sat1Q    <= npSat;
      alphaQ   <= alphaLookup(aiQ);
      usePrevQ <= (aiQ != 4'd0);
      prev2Q   <= prev1Q;
    end
  end

  // Stage 3: weighted update, truncate toward zero, final clamp
  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod, negProd, step, total;
  logic signed [DATA_W-1:0] binNext;
  logic                     satFinal;

  always_comb begin
    diff     = $signed({1'b0, npQ}) - (usePrevQ ? DIFF_W'(prev2Q) : DIFF_W'(0));
    prod     = PROD_W'(diff) * PROD_W'($signed({1'b0, alphaQ}));
    negProd  = -prod;
    step     = prod[PROD_W-1] ? -(negProd >>> ALPHA_FRAC) : (prod >>> ALPHA_FRAC);
    total    = PROD_W'(prev2Q) + step;
    satFinal = 1'b0;
    if (total > BIN_MAX) begin
      binNext  = DATA_W'(BIN_MAX);
      satFinal = 1'b1;
    end else if (total < BIN_MIN) begin
      binNext  = DATA_W'(BIN_MIN);
      satFinal = 1'b1;
    end else begin
      binNext  = total[DATA_W-1:0];
    end
  end

  assign satNow = sat1Q | satFinal;

  always_ff @(posedge clk) begin
    if (stb.s3En) binOut <= binNext;
  end

endmodule

// File: rtl/pdp_update_ctrl.sv
module pdp_update_ctrl
  import pdp_update_pkg::*;
#(
  parameter int NUM_RES = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic [$clog2(NUM_RES)-1:0] resId,
  input  logic                       clrSat,
  input  logic                       satNow,
  output pdpStrobe_t                 stb,
  output logic                       outValid,
  output logic [$clog2(NUM_RES)-1:0] outResId,
  output logic                       outSat
);

  localparam int ID_W = $clog2(NUM_RES);

  logic            v1, v2, v3;
  logic [ID_W-1:0] id1, id2;
  logic            clr1, clr2;
  logic [NUM_RES-1:0] satFlags;
  logic            flagNext;

  assign stb.s1En = inValid;
  assign stb.s2En = v1;
  assign stb.s3En = v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (inValid) begin
      id1  <= resId;
      clr1 <= clrSat;
    end
    if (v1) begin
      id2  <= id1;
      clr2 <= clr1;
    end
  end

  // A clear drops history; this update's own saturation still counts.
  assign flagNext = clr2 ? satNow : (satFlags[id2] | satNow);

  always_ff @(posedge clk) begin
    if (rst) begin
      satFlags <= '0;
      outSat   <= 1'b0;
      outResId <= '0;
    end else if (v2) begin
      satFlags[id2] <= flagNext;
      outSat        <= flagNext;
      outResId      <= id2;
    end
  end

  assign outValid = v3;

endmodule

// File: rtl/pdp_update.sv
module pdp_update
  import pdp_update_pkg::*;
#(
  parameter int SUM_W       = 18,
  parameter int DATA_W      = 18,
  parameter int SHIFT_W     = 4,
  parameter int WIN_PER_BIT = 4,
  parameter int BITS_MAX    = 8,
  parameter int NUM_RES     = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SUM_W-1:0]    iSum,
  input  logic signed [SUM_W-1:0]    qSum,
  input  logic [$clog2(BITS_MAX*WIN_PER_BIT+1)-1:0] nLen,
  input  logic [SHIFT_W-1:0]         pwrShift,
  input  logic [3:0]                 alphaIdx,
  input  logic signed [DATA_W-1:0]   prevBin,
  input  logic [$clog2(NUM_RES)-1:0] resId,
  input  logic                       clrSat,
  output logic                       outValid,
  output logic signed [DATA_W-1:0]   newBin,
  output logic [$clog2(NUM_RES)-1:0] outResId,
  output logic                       outSat
);

  pdpStrobe_t stb;
  logic       satNow;

  pdp_update_ctrl #(.NUM_RES(NUM_RES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .resId(resId), .clrSat(clrSat),
    .satNow(satNow), .stb(stb), .outValid(outValid), .outResId(outResId),
    .outSat(outSat)
  );

  pdp_update_dp #(
    .SUM_W(SUM_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W),
    .WIN_PER_BIT(WIN_PER_BIT), .BITS_MAX(BITS_MAX)
  ) u_dp (
    .clk(clk), .stb(stb), .iSum(iSum), .qSum(qSum), .nLen(nLen),
    .pwrShift(pwrShift), .alphaIdx(alphaIdx), .prevBin(prevBin),
    .binOut(newBin), .satNow(satNow)
  );

endmodule

// File: rtl/pdp_update_checker.sv
module pdp_update_checker #(
  parameter int SUM_W   = 18,
  parameter int DATA_W  = 18,
  parameter int ID_W    = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic signed [SUM_W-1:0]  iSum,
  input logic signed [SUM_W-1:0]  qSum,
  input logic [3:0]               alphaIdx,
  input logic signed [DATA_W-1:0] prevBin,
  input logic [ID_W-1:0]          resId,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] newBin,
  input logic [ID_W-1:0]          outResId,
  input logic                     outSat
);

  // Counts edges since reset so three-deep history is never pre-reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_id_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && outValid) |-> (outResId == $past(resId, 3)));

  assert_zero_input_keeps_bin_R3: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && outValid && $past(alphaIdx, 3) == 4'd0 &&
     $past(iSum, 3) == '0 && $past(qSum, 3) == '0) |-> (newBin == $past(prevBin, 3)));

  assert_accumulate_grows_R5: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && outValid && $past(alphaIdx, 3) == 4'd0) |-> (newBin >= $past(prevBin, 3)));

  assert_filter_stays_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && outValid && $past(alphaIdx, 3) != 4'd0 && $past(prevBin, 3) >= 0)
      |-> (newBin >= 0));

endmodule

bind pdp_update pdp_update_checker #(
  .SUM_W(SUM_W), .DATA_W(DATA_W), .ID_W($clog2(NUM_RES))
) chk (
  .clk(clk), .rst(rst), .inValid(inValid), .iSum(iSum), .qSum(qSum),
  .alphaIdx(alphaIdx), .prevBin(prevBin), .resId(resId), .outValid(outValid),
  .newBin(newBin), .outResId(outResId), .outSat(outSat)
);

// File: tb/pdp_update_test.sv
module pdp_update_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [17:0] iSum = '0, qSum = '0, prevBin = '0;
  logic [5:0] nLen = '0, resId = '0;
  logic [3:0] pwrShift = '0, alphaIdx = '0;
  logic clrSat = 1'b0;
  logic outValid;
  logic signed [17:0] newBin;
  logic [5:0] outResId;
  logic outSat;

  always #2 clk = ~clk;

  pdp_update uut (
    .clk(clk), .rst(rst), .inValid(inValid), .iSum(iSum), .qSum(qSum),
    .nLen(nLen), .pwrShift(pwrShift), .alphaIdx(alphaIdx), .prevBin(prevBin),
    .resId(resId), .clrSat(clrSat), .outValid(outValid), .newBin(newBin),
    .outResId(outResId), .outSat(outSat)
  );

  typedef struct {
    int    due;
    int    bin;
    int    id;
    bit    sat;
    string tag;
  } expect_t;

  expect_t pending[$];
  bit      refFlag [64];
  int      cyc = 0;
  int      checks = 0;
  int      errors = 0;
  bit      done = 1'b0;

  function automatic longint alphaOf(int k);
    case (k)
      0, 1: return 131072;
      2:  return 262144 / 3;
      3:  return 131072 / 2;
      4:  return 131072 / 3;
      5:  return 131072 / 4;
      6:  return 131072 / 6;
      7:  return 131072 / 8;
      8:  return 131072 / 12;
      9:  return 131072 / 16;
      10: return 131072 / 24;
      11: return 131072 / 32;
      12: return 131072 / 48;
      13: return 131072 / 64;
      14: return 131072 / 96;
      default: return 131072 / 128;
    endcase
  endfunction

  task automatic refModel(input int iv, qv, n, sh, ai, p, output int bin, output bit sat);
    longint pw, rc, t, np, d, st, r;
    pw  = longint'(iv) * iv + longint'(qv) * qv;
    rc  = (n >= 1 && n <= 32) ? (longint'(131072) / n) : 0;
    t   = (pw * rc) / (longint'(1) << (35 - sh));
    sat = 1'b0;
    np  = t;
    if (t > 131071) begin np = 131071; sat = 1'b1; end
    d   = np - ((ai == 0) ? 0 : p);
    st  = (d * alphaOf(ai)) / 131072;
    r   = p + st;
    if (r > 131071) begin r = 131071; sat = 1'b1; end
    if (r < -131072) begin r = -131072; sat = 1'b1; end
    bin = int'(r);
  endtask

  task automatic push(input int iv, qv, n, sh, ai, p, id, input bit clr, input string tag);
    expect_t e;
    bit s;
    @(negedge clk);
    inValid  = 1'b1;
    iSum     = 18'(iv);
    qSum     = 18'(qv);
    nLen     = 6'(n);
    pwrShift = 4'(sh);
    alphaIdx = 4'(ai);
    prevBin  = 18'(p);
    resId    = 6'(id);
    clrSat   = clr;
    refModel(iv, qv, n, sh, ai, p, e.bin, s);
    refFlag[id] = clr ? s : (refFlag[id] | s);
    e.sat = refFlag[id];
    e.id  = id;
    e.due = cyc + 3;
    e.tag = tag;
    pending.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Output monitor, one time unit after each rising edge.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (!rst) begin
      if (outValid) begin
        if (pending.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected outValid actual=1 expected=0 at cycle %0d", cyc);
        end else begin
          expect_t e;
          e = pending.pop_front();
          checks++;
          if (e.due != cyc) begin
            errors++;
            $display("FAIL R2: output cycle actual=%0d expected=%0d", cyc, e.due);
          end
          checks++;
          if (int'(newBin) != e.bin) begin
            errors++;
            $display("FAIL %s: newBin actual=%0d expected=%0d", e.tag, newBin, e.bin);
          end
          checks++;
          if (int'(outResId) != e.id) begin
            errors++;
            $display("FAIL R2: outResId actual=%0d expected=%0d", outResId, e.id);
          end
          checks++;
          if (outSat != e.sat) begin
            errors++;
            $display("FAIL %s: outSat actual=%0b expected=%0b", e.tag, outSat, e.sat);
          end
        end
      end else if (pending.size() != 0 && pending[0].due == cyc) begin
        checks++; errors++;
        $display("FAIL R2: outValid actual=0 expected=1 at cycle %0d", cyc);
        void'(pending.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) refFlag[k] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: outValid after reset actual=%b expected=0", outValid);
    end
    // R1: first clean update of an ID reports no saturation
    push(100, -200, 4, 10, 0, 0, 5, 1'b0, "R1");
    idle(4);
    // R3: small powers, several lengths including 0 and beyond 32
    push(1000, 0, 1, 15, 0, 0, 1, 1'b0, "R3");
    push(-3000, 4000, 3, 12, 0, 10, 2, 1'b0, "R3");
    push(5000, 5000, 32, 15, 0, -50, 3, 1'b0, "R3");
    push(7000, 7000, 0, 15, 0, 77, 4, 1'b0, "R3");
    push(7000, 7000, 40, 15, 0, 77, 4, 1'b0, "R3");
    push(0, 0, 8, 15, 0, 1234, 6, 1'b0, "R3");
    idle(4);
    // R4: full-scale sums overflow the power clamp
    push(-131072, -131072, 1, 15, 0, 0, 10, 1'b0, "R4");
    push(131071, 0, 2, 3, 0, -131072, 11, 1'b0, "R4");
    idle(4);
    // R5: accumulation
    push(20000, -10000, 6, 8, 0, 500, 12, 1'b0, "R5");
    push(-15000, 9000, 24, 11, 0, -90000, 13, 1'b0, "R5");
    idle(4);
    // R6: every weighting index, bin above and below the power
    for (int k = 1; k < 16; k++) begin
      push(12000, 3000, 5, 9, k, 60000, 20, 1'b0, "R6");
      push(12000, 3000, 5, 9, k, -77777, 21, 1'b0, "R6");
      push(1, 0, 7, 0, k, 99, 22, 1'b0, "R6");
    end
    idle(4);
    // R7: accumulation past the top of the bin range
    push(30000, 30000, 2, 10, 0, 130000, 30, 1'b0, "R7");
    push(500, 0, 1, 15, 0, 131071, 31, 1'b0, "R7");
    idle(4);
    // R8: sticky flag on ID 40, neighbour 41 untouched
    push(-131072, 131071, 1, 15, 1, 0, 40, 1'b0, "R8");
    push(10, 10, 4, 0, 0, 0, 40, 1'b0, "R8");
    push(10, 10, 4, 0, 0, 0, 41, 1'b0, "R8");
    push(10, 10, 4, 0, 3, 5, 40, 1'b0, "R8");
    idle(4);
    // R9: clear with a clean update, then clear together with saturation
    push(10, 10, 4, 0, 0, 0, 40, 1'b1, "R9");
    push(10, 10, 4, 0, 0, 0, 40, 1'b0, "R9");
    push(131071, 131071, 1, 15, 0, 0, 40, 1'b1, "R9");
    push(10, 10, 4, 0, 0, 0, 40, 1'b0, "R9");
    idle(4);
    // R2: random stream, back to back with occasional gaps
    for (int k = 0; k < 400; k++) begin
      int iv, qv, p, sh;
      iv = int'($urandom_range(0, 262143)) - 131072;
      qv = int'($urandom_range(0, 262143)) - 131072;
      p  = int'($urandom_range(0, 262143)) - 131072;
      sh = int'($urandom_range(0, 15));
      if ((k % 3) != 0) begin
        iv = iv / 64;
        qv = qv / 64;
      end
      push(iv, qv, int'($urandom_range(0, 40)), sh, int'($urandom_range(0, 15)), p,
           int'($urandom_range(0, 63)), ($urandom_range(0, 7) == 0), "R2");
      if ($urandom_range(0, 9) == 0) idle(1);
    end
    idle(6);
    checks++;
    if (pending.size() != 0) begin
      errors++;
      $display("FAIL R2: outstanding updates actual=%0d expected=0", pending.size());
    end
    done = 1'b1;
    finishRun();
  end

endmodule